// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block sits between the decoder of a floating-point unit and its register file read and write ports. It takes one decoded data-processing command: precision, destination and two source register indices, a vector length and a stride field, and the operand kind. It then issues one tuple of register indices per cycle, so that a short-vector operation runs as a series of scalar steps. Each tuple carries a compute flag and a final-element flag. The arithmetic and the register storage sit outside the block.

Register indices are grouped into banks. A single-precision bank holds 8 of 32 registers and a double-precision bank holds 4 of 16. Indices advance by a stride-derived step and wrap inside the bank they started in. A destination in the first bank means a scalar operation. A second source in the first bank is held fixed, which gives mixed scalar/vector operation. A one-source operation with a fixed source is computed once, and the result is then written to every destination in turn.

Top module: `svs_index_seq`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and its first tuple is valid on the next cycle. `cmd_valid` while busy has no effect on the tuple stream.
- R2: The bank-select bits are index bits [4:3] for single precision (`cmd_double`=0) and bits [3:2] for double precision (`cmd_double`=1). If the destination's bank-select bits are zero, exactly one tuple is issued, carrying the command's own indices, with `out_last`=1.
- R3: `cmd_op_kind` encoding: 2'b00 = two sources, 2'b01 = one source (source in `cmd_src_b`), 2'b10 and 2'b11 = always scalar. An always-scalar command issues one tuple whatever its length and indices.
- R4: A vector command issues `cmd_len`+1 tuples. `out_last` is high on the final tuple only, and `out_valid` falls on the cycle after the final tuple is taken.
- R5: The index step is `cmd_stride`+1 in single precision and (`cmd_stride`>>1)+1 in double precision.
- R6: An advancing index keeps its bank-select bits. Its low bits (index mod bank size, 8 or 4) advance by the step, modulo the bank size.
- R7: In two-source form, destination and first source advance on every element. The second source advances too, unless it lies in bank zero, in which case it stays fixed.
- R8: In one-source form with the source outside bank zero, destination and `cmd_src_b` advance each element, and `out_src_a` stays at the command value.
- R9: In one-source vector form with the source in bank zero (replicate), the first tuple has `out_compute`=1. The remaining `cmd_len` tuples have `out_compute`=0, advancing destinations and unchanged sources. Every other tuple has `out_compute`=1.
- R10: While `out_valid` is high and `out_ready` is low, all tuple outputs hold their values.
- R11: After reset, `out_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_double | input | 1 | 1 = double precision |
| cmd_op_kind | input | 2 | Operand kind, see R3 |
| cmd_dst | input | 5 | Destination register index |
| cmd_src_a | input | 5 | First source register index |
| cmd_src_b | input | 5 | Second (or sole) source register index |
| cmd_len | input | 3 | Vector length minus one |
| cmd_stride | input | 2 | Stride field |
| out_valid | output | 1 | Tuple valid |
| out_ready | input | 1 | Consumer takes the tuple |
| out_dst | output | 5 | Destination index of this element |
| out_src_a | output | 5 | First source index of this element |
| out_src_b | output | 5 | Second source index of this element |
| out_compute | output | 1 | 1 = compute, 0 = write previous result only |
| out_last | output | 1 | Final tuple of the command |

## Verification
A wrong element counter shows up as a wrong tuple count, or as `out_last` on the wrong tuple, within `cmd_len`+1 handshakes. A wrong step or bank mask shows up as a wrong index on the second tuple of a vector command. A lane that advances when it should not, or holds when it should advance, shows up on that same second tuple. The stimulus therefore runs several stride, precision and bank combinations, including a wrap case and a replicate case, and compares every tuple against a model built from the requirements. Back-pressure and busy-time commands check that state changes only on a handshake.

// File: rtl/svs_pkg.sv
package svs_pkg;

    parameter int unsigned IDX_W    = 5;
    parameter int unsigned LEN_W    = 3;
    parameter int unsigned STRIDE_W = 2;
    parameter int unsigned SGL_BANK = 8;
    parameter int unsigned DBL_BANK = 4;

    typedef logic [IDX_W-1:0]    vidx_t;
    typedef logic [LEN_W-1:0]    vlen_t;
    typedef logic [STRIDE_W-1:0] vstride_t;

    // low bits select within a bank, high bits select the bank
    localparam vidx_t SGL_LO = vidx_t'(SGL_BANK - 1);
    localparam vidx_t SGL_HI = ~SGL_LO;
    localparam vidx_t DBL_LO = vidx_t'(DBL_BANK - 1);
    localparam vidx_t DBL_HI = vidx_t'((1 << (IDX_W - 1)) - 1) & ~DBL_LO;

    typedef enum logic [1:0] {
        OPK_DUAL   = 2'd0,
        OPK_MONO   = 2'd1,
        OPK_SCALAR = 2'd2,
        OPK_RSVD   = 2'd3
    } opk_e;

    typedef struct packed {
        logic     dbl;
        opk_e     opk;
        vidx_t    dst;
        vidx_t    src_a;
        vidx_t    src_b;
        vlen_t    len;
        vstride_t stride;
    } svs_cmd_t;

    typedef struct packed {
        vidx_t hi_mask;
        vidx_t lo_mask;
        vidx_t step;
        vlen_t last_pos;
        logic  adv_a;
        logic  adv_b;
        logic  replicate;
    } svs_plan_t;

    function automatic vidx_t bank_hi(input logic dbl);
        return dbl ? DBL_HI : SGL_HI;
    endfunction

    function automatic vidx_t bank_lo(input logic dbl);
        return dbl ? DBL_LO : SGL_LO;
    endfunction

    function automatic vidx_t elem_step(input logic dbl, input vstride_t stride);
        vstride_t half;
        half = stride >> 1;
        return dbl ? (vidx_t'(half) + vidx_t'(1)) : (vidx_t'(stride) + vidx_t'(1));
    endfunction

    function automatic vidx_t next_idx(input vidx_t r, input vidx_t step,
                                       input vidx_t lo, input vidx_t hi);
        return ((r + step) & lo) | (r & hi);
    endfunction

endpackage

// File: rtl/svs_plan_dec.sv
module svs_plan_dec
    import svs_pkg::*;
(
    input  svs_cmd_t  cmd,
    output svs_plan_t plan
);
    logic is_vec;
    logic b_fixed;
    vidx_t hi;

    always_comb begin
        hi      = bank_hi(cmd.dbl);
        b_fixed = (cmd.src_b & hi) == '0;
        is_vec  = ((cmd.opk == OPK_DUAL) || (cmd.opk == OPK_MONO))
                  && (cmd.len != '0) && ((cmd.dst & hi) != '0);

        plan.hi_mask   = hi;
        plan.lo_mask   = bank_lo(cmd.dbl);
        plan.step      = elem_step(cmd.dbl, cmd.stride);
        plan.last_pos  = is_vec ? cmd.len : '0;
        plan.adv_a     = (cmd.opk == OPK_DUAL);
        plan.adv_b     = !b_fixed;
        plan.replicate = is_vec && (cmd.opk == OPK_MONO) && b_fixed;
    end
endmodule

// File: rtl/svs_idx_lane.sv
module svs_idx_lane
    import svs_pkg::*;
(
    input  vidx_t cur,
    input  vidx_t step,
    input  vidx_t lo_mask,
    input  vidx_t hi_mask,
    input  logic  en,
    output vidx_t nxt
);
    always_comb begin
        nxt = en ? next_idx(cur, step, lo_mask, hi_mask) : cur;
    end
endmodule

// File: rtl/svs_elem_ctr.sv
module svs_elem_ctr
    import svs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  vlen_t load_val,
    input  logic  dec,
    output logic  is_last
);
    vlen_t remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - vlen_t'(1);
        end
    end

    assign is_last = (remain == '0);

    // R4: never step past the final element
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> (remain != '0));
endmodule

// File: rtl/svs_index_seq.sv
module svs_index_seq
    import svs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_double,
    input  logic [1:0]       cmd_op_kind,
    input  logic [IDX_W-1:0] cmd_dst,
    input  logic [IDX_W-1:0] cmd_src_a,
    input  logic [IDX_W-1:0] cmd_src_b,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [STRIDE_W-1:0] cmd_stride,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_dst,
    output logic [IDX_W-1:0] out_src_a,
    output logic [IDX_W-1:0] out_src_b,
    output logic             out_compute,
    output logic             out_last
);
    localparam int unsigned LANES = 3;
    localparam int unsigned L_DST = 0;
    localparam int unsigned L_A   = 1;
    localparam int unsigned L_B   = 2;

    svs_cmd_t  cmd_in;
    svs_plan_t plan_d;
    svs_plan_t plan_q;
    logic      busy;
    logic      comp_q;
    vidx_t     cur_q [LANES];
    vidx_t     nxt   [LANES];
    logic [LANES-1:0] lane_en;
    logic      accept;
    logic      fire;
    logic      last;

    always_comb begin
        cmd_in.dbl    = cmd_double;
        cmd_in.opk    = opk_e'(cmd_op_kind);
        cmd_in.dst    = cmd_dst;
        cmd_in.src_a  = cmd_src_a;
        cmd_in.src_b  = cmd_src_b;
        cmd_in.len    = cmd_len;
        cmd_in.stride = cmd_stride;
    end

    svs_plan_dec u_dec (
        .cmd  (cmd_in),
        .plan (plan_d)
    );

    assign accept  = cmd_valid && !busy;
    assign fire    = busy && out_ready;
    assign lane_en = {plan_q.adv_b, plan_q.adv_a, 1'b1};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            svs_idx_lane u_lane (
                .cur     (cur_q[g]),
                .step    (plan_q.step),
                .lo_mask (plan_q.lo_mask),
                .hi_mask (plan_q.hi_mask),
                .en      (lane_en[g]),
                .nxt     (nxt[g])
            );
        end
    endgenerate

    svs_elem_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (plan_d.last_pos),
        .dec      (fire && !last),
        .is_last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            comp_q <= 1'b0;
            plan_q <= '0;
            for (int i = 0; i < LANES; i++) cur_q[i] <= '0;
        end else if (accept) begin
            busy         <= 1'b1;
            comp_q       <= 1'b1;
            plan_q       <= plan_d;
            cur_q[L_DST] <= cmd_dst;
            cur_q[L_A]   <= cmd_src_a;
            cur_q[L_B]   <= cmd_src_b;
        end else if (fire) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                comp_q <= !plan_q.replicate;
                for (int i = 0; i < LANES; i++) cur_q[i] <= nxt[i];
            end
        end
    end

    assign cmd_ready   = !busy;
    assign out_valid   = busy;
    assign out_dst     = cur_q[L_DST];
    assign out_src_a   = cur_q[L_A];
    assign out_src_b   = cur_q[L_B];
    assign out_compute = comp_q;
    assign out_last    = busy && last;

    assert_first_tuple_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> out_valid);

    assert_drop_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    assert_bank_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last)
        |=> ((out_dst & plan_q.hi_mask) == $past(out_dst & plan_q.hi_mask)));

    assert_replicate_write_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last && plan_q.replicate)
        |=> (!out_compute && $stable(out_src_b)));

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_dst) && $stable(out_src_a)
             && $stable(out_src_b) && $stable(out_last) && $stable(out_compute)));
endmodule

// File: tb/svs_index_seq_test.sv
`timescale 1ns/1ps
module svs_index_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_double = 1'b0;
    logic [1:0] cmd_op_kind = 2'd0;
    logic [4:0] cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
    logic [2:0] cmd_len = '0;
    logic [1:0] cmd_stride = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [4:0] out_dst, out_src_a, out_src_b;
    logic       out_compute, out_last;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    svs_index_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_double(cmd_double), .cmd_op_kind(cmd_op_kind), .cmd_dst(cmd_dst),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_len(cmd_len),
        .cmd_stride(cmd_stride), .out_valid(out_valid), .out_ready(out_ready),
        .out_dst(out_dst), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_compute(out_compute), .out_last(out_last)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] m_adv(input logic [4:0] r, input logic [4:0] st,
                                         input logic dbl);
        logic [4:0] lo, hi;
        lo = dbl ? 5'h03 : 5'h07;
        hi = dbl ? 5'h0C : 5'h18;
        return ((r + st) & lo) | (r & hi);
    endfunction

    // Issue one command and compare every tuple against the requirement model.
    task automatic run_case(input string req, input logic dbl, input logic [1:0] opk,
                            input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                            input logic [2:0] len, input logic [1:0] st,
                            input bit bp, input bit poke);
        logic [4:0] ed [8];
        logic [4:0] ea [8];
        logic [4:0] eb [8];
        logic       ec [8];
        logic [4:0] hi, step, md, ma, mb;
        logic [4:0] sd, sa, sb;
        logic       vec, bfix, rep, held, done, sl;
        int n, got, cyc;
        hi   = dbl ? 5'h0C : 5'h18;
        step = dbl ? (5'(st >> 1) + 5'd1) : (5'(st) + 5'd1);
        vec  = (opk == 2'd0 || opk == 2'd1) && len != 0 && (d & hi) != 0;
        bfix = (b & hi) == 0;
        rep  = vec && opk == 2'd1 && bfix;
        n    = vec ? int'(len) + 1 : 1;
        md = d; ma = a; mb = b;
        for (int i = 0; i < n; i++) begin
            ed[i] = md; ea[i] = ma; eb[i] = mb; ec[i] = !(rep && i > 0);
            md = m_adv(md, step, dbl);
            if (!rep) begin
                if (opk == 2'd0) ma = m_adv(ma, step, dbl);
                if (!bfix) mb = m_adv(mb, step, dbl);
            end
        end

        @(negedge clk);
        chk("R1", {req, " ready before command"}, int'(cmd_ready), 1);
        cmd_double = dbl; cmd_op_kind = opk; cmd_dst = d; cmd_src_a = a;
        cmd_src_b = b; cmd_len = len; cmd_stride = st; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1", {req, " first tuple next cycle"}, int'(out_valid), 1);
        if (poke) begin
            cmd_valid = 1'b1; cmd_dst = 5'h1F; cmd_src_a = 5'h1E; cmd_src_b = 5'h1D;
            cmd_len = 3'd7; cmd_op_kind = 2'd0; cmd_double = 1'b0;
            chk("R1", {req, " ready low while busy"}, int'(cmd_ready), 0);
        end
        got = 0; cyc = 0; held = 1'b0; done = 1'b0;
        sd = '0; sa = '0; sb = '0; sl = 1'b0;
        while (!done && cyc < 100) begin
            out_ready = bp ? (cyc % 3 != 2) : 1'b1;
            #1;
            if (held && out_valid) begin
                chk("R10", {req, " dst held under stall"}, int'(out_dst), int'(sd));
                chk("R10", {req, " src_a held under stall"}, int'(out_src_a), int'(sa));
                chk("R10", {req, " src_b held under stall"}, int'(out_src_b), int'(sb));
                chk("R10", {req, " last held under stall"}, int'(out_last), int'(sl));
                held = 1'b0;
            end
            if (out_valid && !out_ready) begin
                sd = out_dst; sa = out_src_a; sb = out_src_b; sl = out_last; held = 1'b1;
            end
            if (out_valid && out_ready) begin
                if (got < n) begin
                    chk(req, $sformatf("dst of element %0d", got), int'(out_dst), int'(ed[got]));
                    chk(req, $sformatf("src_a of element %0d", got), int'(out_src_a), int'(ea[got]));
                    chk(req, $sformatf("src_b of element %0d", got), int'(out_src_b), int'(eb[got]));
                    chk(req, $sformatf("compute of element %0d", got), int'(out_compute), int'(ec[got]));
                    chk("R4", $sformatf("%s last flag element %0d", req, got),
                        int'(out_last), int'(got == n - 1));
                end
                got++;
                if (out_last || got > n) done = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        out_ready = 1'b0;
        chk("R4", {req, " tuple count"}, got, n);
        chk("R4", {req, " valid drops after last"}, int'(out_valid), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11", "valid after reset", int'(out_valid), 0);
        chk("R11", "ready after reset", int'(cmd_ready), 1);
    endtask

    task automatic t_scalar_dst();
        run_case("R2", 1'b0, 2'd0, 5'd5, 5'd17, 5'd25, 3'd3, 2'd0, 1'b0, 1'b0);
        run_case("R2", 1'b1, 2'd0, 5'd2, 5'd6, 5'd9, 3'd2, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_vector_dual();
        run_case("R7", 1'b0, 2'd0, 5'd8, 5'd16, 5'd24, 3'd3, 2'd0, 1'b0, 1'b0);
        run_case("R7", 1'b0, 2'd0, 5'd8, 5'd16, 5'd3, 3'd2, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_wrap();
        run_case("R6", 1'b0, 2'd0, 5'd13, 5'd21, 5'd29, 3'd3, 2'd1, 1'b0, 1'b0);
    endtask

    task automatic t_step();
        run_case("R5", 1'b0, 2'd0, 5'd16, 5'd8, 5'd24, 3'd2, 2'd3, 1'b0, 1'b0);
        run_case("R5", 1'b1, 2'd0, 5'd4, 5'd8, 5'd13, 3'd3, 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_op_kinds();
        run_case("R3", 1'b0, 2'd2, 5'd8, 5'd16, 5'd24, 3'd3, 2'd0, 1'b0, 1'b0);
        run_case("R3", 1'b0, 2'd3, 5'd9, 5'd17, 5'd25, 3'd5, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_one_source();
        run_case("R8", 1'b0, 2'd1, 5'd8, 5'd0, 5'd16, 3'd2, 2'd2, 1'b0, 1'b0);
    endtask

    task automatic t_replicate();
        run_case("R9", 1'b0, 2'd1, 5'd9, 5'd4, 5'd2, 3'd3, 2'd0, 1'b0, 1'b0);
        run_case("R9", 1'b1, 2'd1, 5'd5, 5'd0, 5'd1, 3'd2, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_length();
        run_case("R4", 1'b0, 2'd0, 5'd8, 5'd16, 5'd24, 3'd0, 2'd0, 1'b0, 1'b0);
        run_case("R4", 1'b0, 2'd0, 5'd24, 5'd8, 5'd16, 3'd7, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_backpressure();
        run_case("R10", 1'b0, 2'd0, 5'd13, 5'd21, 5'd29, 3'd5, 2'd1, 1'b1, 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_case("R1", 1'b0, 2'd0, 5'd10, 5'd18, 5'd26, 3'd3, 2'd0, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_scalar_dst();
        t_vector_dual();
        t_wrap();
        t_step();
        t_op_kinds();
        t_one_source();
        t_replicate();
        t_length();
        t_backpressure();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule